// File: doc/BRIEF.md
# Dual-Bank Connection Memory with Hardware Block Fill

This block stores the per-output-channel connection words of a time-slot interchange switch. It has two banks of equal depth, each 16 bits wide. The local bank serves the local outputs and the backplane bank serves the backplane outputs. A single processor access port reaches three small registers and the two banks. The memory-select field of the control register decides which bank a memory-space access reaches.

After power-up, software can start a hardware fill instead of writing every word. Software first sets the arm bit in the control register, then sets the enable bit in the fill register. The sequencer then walks one shared address counter across the whole depth, one word per clock. Each cycle it writes the same address in both banks. Every local word receives the 3-bit local pattern in bits [15:13], and every backplane word receives the 3-bit backplane pattern in bits [15:13]. All lower bits are written as zero. At the end the sequencer clears the enable bit and sets a done flag. While the fill runs, processor writes are dropped and memory reads return zero, but the status register stays readable.

The processor port uses one request per cycle. `acc_mem` chooses between register space and memory space. Read data is returned one cycle after the request, qualified by `rd_valid`.

Top module: `conn_mem_init`

## Requirements
- R1: After reset, `rd_valid` is 0, and the control register (address 0), fill register (address 1) and status register (address 2) all read as zero.
- R2: With memory-select `ctl[2:0]` = 000, memory-space writes update the local bank and memory-space reads return the local word at `acc_addr`. `rd_valid` is 1 and `rd_data` is valid in the cycle after the request.
- R3: With memory-select = 001, memory-space accesses reach the backplane bank, and that bank's contents are independent of the local bank.
- R4: With any memory-select value other than 000 or 001, memory-space writes change neither bank and memory-space reads return zero.
- R5: A fill starts only when control bit 3 (arm) and fill-register bit 0 (enable) are both 1 and one of them has just been written to 1. Setting arm with enable at 0 starts nothing.
- R6: A fill writes {local pattern (fill-register bits [3:1]), 13'b0} into every local-bank address.
- R7: A fill writes {backplane pattern (fill-register bits [6:4]), 13'b0} into every backplane-bank address. Both banks are written at the same address in the same cycle, one address per clock. Status bit 0 (busy) is therefore seen as 1 for exactly DEPTH consecutive per-cycle status reads.
- R8: When a fill finishes, busy (status bit 0) drops, done (status bit 1) becomes 1, and the enable bit clears while both pattern fields keep their values.
- R9: While a fill is running, processor writes to any register or bank are dropped, memory reads return zero, and status reads still report busy.
- R10: Starting a fill clears the done flag for as long as busy is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Access request, one per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_mem | input | 1 | 1 = memory space, 0 = register space (addresses 0 to 2) |
| acc_addr | input | ADDR_W | Word address (register index in acc_addr[1:0]) |
| acc_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 16 | Read data |

## Verification
The bench builds the block with ADDR_W = 6. With that value each bank has 64 words, so the bench can read back every word of both banks after each of two fills. It can also poll the status register on every cycle and confirm that busy is seen for exactly 64 reads. The small depth keeps the end-of-fill handoff reachable in a short run, including the clearing of the enable bit, the setting of done, and done being cleared again by a second fill. The way accesses are dropped during a fill is the same at any depth, so the bench exercises it at this size.

// File: rtl/cmi_pkg.sv
package cmi_pkg;
  localparam int WORD_W = 16;
  localparam int PAT_W  = 3;
  localparam int MS_W   = 3;

  localparam logic [MS_W-1:0] MS_LOCAL = 3'b000;
  localparam logic [MS_W-1:0] MS_BACK  = 3'b001;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_FILL = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;

  typedef enum logic [1:0] {
    RSRC_REG  = 2'd0,
    RSRC_LOC  = 2'd1,
    RSRC_BP   = 2'd2,
    RSRC_ZERO = 2'd3
  } rsrc_t;

  // Fill word: pattern in the top bits, zeros below.
  function automatic logic [WORD_W-1:0] fill_word(input logic [PAT_W-1:0] pat);
    return {pat, {(WORD_W-PAT_W){1'b0}}};
  endfunction
endpackage

// File: rtl/cmi_bank.sv
module cmi_bank #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/cmi_regs.sv
module cmi_regs
  import cmi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [6:0]        wdata,
  input  logic              fill_start,
  input  logic              fill_end,
  input  logic              busy,
  output logic [MS_W-1:0]   ms,
  output logic              arm,
  output logic              en,
  output logic [PAT_W-1:0]  loc_pat,
  output logic [PAT_W-1:0]  bp_pat,
  output logic              done,
  output logic [WORD_W-1:0] rd_word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ms      <= '0;
      arm     <= 1'b0;
      en      <= 1'b0;
      loc_pat <= '0;
      bp_pat  <= '0;
      done    <= 1'b0;
    end else begin
      if (wr_en && addr == RA_CTRL) begin
        ms  <= wdata[2:0];
        arm <= wdata[3];
      end
      if (wr_en && addr == RA_FILL) begin
        en      <= wdata[0];
        loc_pat <= wdata[3:1];
        bp_pat  <= wdata[6:4];
      end
      if (fill_end)   en   <= 1'b0;
      if (fill_start) done <= 1'b0;
      else if (fill_end) done <= 1'b1;
    end
  end

  always_comb begin
    rd_word = '0;
    unique case (addr)
      RA_CTRL: rd_word = {{(WORD_W-4){1'b0}}, arm, ms};
      RA_FILL: rd_word = {{(WORD_W-7){1'b0}}, bp_pat, loc_pat, en};
      RA_STAT: rd_word = {{(WORD_W-2){1'b0}}, done, busy};
      default: rd_word = '0;
    endcase
  end
endmodule

// File: rtl/cmi_fill.sv
module cmi_fill #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              en,
  output logic              start,
  output logic              busy,
  output logic              fin,
  output logic [ADDR_W-1:0] addr
);
  logic armed_q;
  logic at_last;

  assign at_last = &addr;
  assign start   = arm & en & ~armed_q & ~busy;
  assign fin     = busy & at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      busy    <= 1'b0;
      addr    <= '0;
    end else begin
      armed_q <= arm & en;
      if (start) begin
        busy <= 1'b1;
        addr <= '0;
      end else if (busy) begin
        addr <= addr + 1'b1;
        if (at_last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/conn_mem_init.sv
module conn_mem_init
  import cmi_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic              acc_wr,
  input  logic              acc_mem,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [15:0]       acc_wdata,
  output logic              rd_valid,
  output logic [15:0]       rd_data
);
  logic [MS_W-1:0]   ms;
  logic              arm, en, done;
  logic [PAT_W-1:0]  loc_pat, bp_pat;
  logic [WORD_W-1:0] reg_word, reg_q;
  logic              fill_start, busy, fill_end;
  logic [ADDR_W-1:0] fill_addr;
  logic              blocked, cpu_reg_we, cpu_mem_wr;
  logic              loc_we, bp_we;
  logic [ADDR_W-1:0] loc_addr, bp_addr;
  logic [WORD_W-1:0] loc_wdata, bp_wdata, loc_rdata, bp_rdata;
  rsrc_t             rsrc_q;

  assign blocked    = busy | fill_start;
  assign cpu_reg_we = acc_req & acc_wr & ~acc_mem & ~blocked;
  assign cpu_mem_wr = acc_req & acc_wr & acc_mem & ~blocked;

  assign loc_we    = busy | (cpu_mem_wr & (ms == MS_LOCAL));
  assign bp_we     = busy | (cpu_mem_wr & (ms == MS_BACK));
  assign loc_addr  = busy ? fill_addr : acc_addr;
  assign bp_addr   = busy ? fill_addr : acc_addr;
  assign loc_wdata = busy ? fill_word(loc_pat) : acc_wdata;
  assign bp_wdata  = busy ? fill_word(bp_pat) : acc_wdata;

  cmi_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cpu_reg_we), .addr(acc_addr[1:0]),
    .wdata(acc_wdata[6:0]), .fill_start(fill_start), .fill_end(fill_end),
    .busy(busy), .ms(ms), .arm(arm), .en(en), .loc_pat(loc_pat),
    .bp_pat(bp_pat), .done(done), .rd_word(reg_word)
  );

  cmi_fill #(.ADDR_W(ADDR_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .arm(arm), .en(en), .start(fill_start),
    .busy(busy), .fin(fill_end), .addr(fill_addr)
  );

  cmi_bank #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_loc (
    .clk(clk), .we(loc_we), .addr(loc_addr), .wdata(loc_wdata), .rdata(loc_rdata)
  );

  cmi_bank #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_bp (
    .clk(clk), .we(bp_we), .addr(bp_addr), .wdata(bp_wdata), .rdata(bp_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rsrc_q   <= RSRC_ZERO;
      reg_q    <= '0;
    end else begin
      rd_valid <= acc_req & ~acc_wr;
      reg_q    <= reg_word;
      if (!acc_mem)               rsrc_q <= RSRC_REG;
      else if (blocked)           rsrc_q <= RSRC_ZERO;
      else if (ms == MS_LOCAL)    rsrc_q <= RSRC_LOC;
      else if (ms == MS_BACK)     rsrc_q <= RSRC_BP;
      else                        rsrc_q <= RSRC_ZERO;
    end
  end

  always_comb begin
    unique case (rsrc_q)
      RSRC_REG:  rd_data = reg_q;
      RSRC_LOC:  rd_data = loc_rdata;
      RSRC_BP:   rd_data = bp_rdata;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cmi_chk.sv
module cmi_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_req,
  input logic              acc_wr,
  input logic              acc_mem,
  input logic [2:0]        ms,
  input logic              arm,
  input logic              en,
  input logic              done,
  input logic [2:0]        loc_pat,
  input logic              busy,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              loc_we,
  input logic              bp_we,
  input logic [ADDR_W-1:0] loc_addr,
  input logic [ADDR_W-1:0] bp_addr,
  input logic [15:0]       loc_wdata,
  input logic [15:0]       bp_wdata
);
  AST_BAD_SEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_wr && acc_mem && !busy && ms > 3'd1) |-> (!loc_we && !bp_we)); // R4
  AST_START_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(arm && en)); // R5
  AST_FILL_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> fill_addr == '0); // R7
  AST_LOCAL_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (loc_wdata[12:0] == 13'd0 && loc_wdata[15:13] == loc_pat)); // R6
  AST_BACK_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bp_wdata[12:0] == 13'd0); // R7
  AST_BANKS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (loc_we && bp_we && loc_addr == bp_addr)); // R7
  AST_ONE_WORD_PER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> fill_addr == $past(fill_addr) + 1'b1); // R7
  AST_END_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && !en)); // R8
  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done); // R10
endmodule

bind conn_mem_init cmi_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_wr(acc_wr),
  .acc_mem(acc_mem), .ms(ms), .arm(arm), .en(en), .done(done),
  .loc_pat(loc_pat), .busy(busy), .fill_addr(fill_addr), .loc_we(loc_we),
  .bp_we(bp_we), .loc_addr(loc_addr), .bp_addr(bp_addr),
  .loc_wdata(loc_wdata), .bp_wdata(bp_wdata)
);

// File: tb/tb_conn_mem_init.sv
module tb_conn_mem_init;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_req = 1'b0, acc_wr = 1'b0, acc_mem = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [15:0]   acc_wdata = '0;
  logic          rd_valid;
  logic [15:0]   rd_data;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  conn_mem_init #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_wr(acc_wr),
    .acc_mem(acc_mem), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [15:0] pat_word(input logic [2:0] p);
    return {p, 13'd0};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic mem, input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    acc_req = 1'b1; acc_wr = 1'b1; acc_mem = mem; acc_addr = a; acc_wdata = d;
    @(posedge clk); #2;
    acc_req = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(input logic mem, input logic [AW-1:0] a, output logic [15:0] d,
                    output logic v);
    @(negedge clk);
    acc_req = 1'b1; acc_wr = 1'b0; acc_mem = mem; acc_addr = a;
    @(posedge clk); #2;
    d = rd_data; v = rd_valid;
    acc_req = 1'b0;
  endtask

  // Polls status every cycle until busy has been seen and then cleared.
  task automatic wait_fill(input bit seen_in, input string req, output int busy_n);
    logic [15:0] s; logic v; bit seen = seen_in;
    busy_n = 0;
    for (int i = 0; i < 4*DEPTH + 16; i++) begin
      rd(1'b0, 2, s, v);
      if (s[0]) begin
        seen = 1'b1; busy_n++;
        if (s[1]) check(req, s, 16'h0001);
      end else if (seen) break;
    end
  endtask

  task automatic t_reset();
    logic [15:0] d; logic v;
    check("R1 rd_valid idle", {15'd0, rd_valid}, 16'd0);
    rd(1'b0, 0, d, v); check("R1 ctrl", d, 16'd0);
    rd(1'b0, 1, d, v); check("R1 fill reg", d, 16'd0);
    rd(1'b0, 2, d, v); check("R1 status", d, 16'd0);
  endtask

  task automatic t_banks();
    logic [15:0] d; logic v;
    wr(1'b0, 0, 16'h0000);
    wr(1'b1, 0, 16'h1234); wr(1'b1, 5, 16'h5A5A); wr(1'b1, DEPTH-1, 16'hBEEF);
    rd(1'b1, 0, d, v);       check("R2 local 0", d, 16'h1234);
    check("R2 rd_valid", {15'd0, v}, 16'd1);
    rd(1'b1, 5, d, v);       check("R2 local 5", d, 16'h5A5A);
    rd(1'b1, DEPTH-1, d, v); check("R2 local top", d, 16'hBEEF);
    wr(1'b0, 0, 16'h0001);
    wr(1'b1, 5, 16'hC3C3);
    rd(1'b1, 5, d, v);       check("R3 backplane 5", d, 16'hC3C3);
    wr(1'b0, 0, 16'h0000);
    rd(1'b1, 5, d, v);       check("R3 local kept", d, 16'h5A5A);
  endtask

  task automatic t_badsel();
    logic [15:0] d; logic v;
    wr(1'b0, 0, 16'h0002);
    wr(1'b1, 5, 16'hAAAA);
    rd(1'b1, 5, d, v);  check("R4 ms=2 read", d, 16'h0000);
    wr(1'b0, 0, 16'h0007);
    rd(1'b1, 0, d, v);  check("R4 ms=7 read", d, 16'h0000);
    wr(1'b0, 0, 16'h0000);
    rd(1'b1, 5, d, v);  check("R4 local untouched", d, 16'h5A5A);
    wr(1'b0, 0, 16'h0001);
    rd(1'b1, 5, d, v);  check("R4 backplane untouched", d, 16'hC3C3);
  endtask

  task automatic t_arm_only();
    logic [15:0] d; logic v;
    wr(1'b0, 0, 16'h0009);
    for (int i = 0; i < 4; i++) begin
      rd(1'b0, 2, d, v); check("R5 arm alone idle", d, 16'h0000);
    end
    rd(1'b1, 5, d, v); check("R5 backplane unchanged", d, 16'hC3C3);
  endtask

  task automatic dump(input logic [2:0] lp, input logic [2:0] bp);
    logic [15:0] d; logic v; int bad_l = 0, bad_b = 0;
    wr(1'b0, 0, 16'h0008);
    for (int a = 0; a < DEPTH; a++) begin
      rd(1'b1, a[AW-1:0], d, v);
      if (d !== pat_word(lp)) begin
        if (bad_l == 0) check("R6 local word", d, pat_word(lp));
        bad_l++;
      end
    end
    if (bad_l == 0) check("R6 all local words", pat_word(lp), pat_word(lp));
    wr(1'b0, 0, 16'h0009);
    for (int a = 0; a < DEPTH; a++) begin
      rd(1'b1, a[AW-1:0], d, v);
      if (d !== pat_word(bp)) begin
        if (bad_b == 0) check("R7 backplane word", d, pat_word(bp));
        bad_b++;
      end
    end
    if (bad_b == 0) check("R7 all backplane words", pat_word(bp), pat_word(bp));
  endtask

  task automatic t_fill1();
    logic [15:0] d; logic v; int n;
    wr(1'b0, 1, 16'h003B);
    repeat (3) @(posedge clk);
    wr(1'b1, 0, 16'hFFFF);
    rd(1'b1, 0, d, v);  check("R9 mem read while busy", d, 16'h0000);
    wr(1'b0, 0, 16'h0002);
    rd(1'b0, 2, d, v);  check("R9 status while busy", d, 16'h0001);
    wait_fill(1'b1, "R10 done during fill 1", n);
    rd(1'b0, 2, d, v);  check("R8 status after fill", d, 16'h0002);
    rd(1'b0, 1, d, v);  check("R8 enable cleared", d, 16'h003A);
    rd(1'b0, 0, d, v);  check("R9 ctrl write dropped", d, 16'h0009);
    dump(3'd5, 3'd3);
  endtask

  task automatic t_fill2();
    logic [15:0] d; logic v; int n;
    wr(1'b0, 1, 16'h0075);
    wait_fill(1'b0, "R10 done during fill 2", n);
    check("R7 busy cycles", n[15:0], DEPTH[15:0]);
    rd(1'b0, 2, d, v);  check("R8 status after fill 2", d, 16'h0002);
    dump(3'd2, 3'd7);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_banks();
    t_badsel();
    t_arm_only();
    t_fill1();
    t_fill2();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule